// File: doc/BRIEF.md
# Reset control register

This block is a single byte-wide register that software reaches through an I/O write and read path. Software writes one byte to it to ask for a whole-system reset. The block answers with a request pulse that lasts one clock cycle and goes to the downstream reset sequencer. The register also keeps one reset-type bit, which software can write and later read back.

A written byte is decoded in one of two ways, chosen by its request bit (bit 2). With bit 2 set, the write counts as a reset request. It raises the pulse and leaves the stored byte as it was. With bit 2 clear, the write is a plain update. It keeps only the type bit (bit 1), and every other stored bit becomes zero.

After one pulse the block disarms. It fires no second pulse until the reset input has been asserted and then released. This stops a write that is repeated while reset is in progress from producing a stream of requests. The synchronous reset clears the stored byte and arms the block again.

Top module: `rst_ctrl_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the stored byte to 0x00, drives `reset_req` low and arms the request logic. After that edge, `rd_data` reads 0x00.
- R2: A write with bit 2 of `wr_data` clear sets the stored byte to `wr_data & 8'h02`. Bit 1 is kept and every other bit becomes 0.
- R3: `rd_data` always shows the stored byte. A plain write becomes visible from the clock edge that accepts it.
- R4: If the block is armed, a write with bit 2 of `wr_data` set drives `reset_req` high for exactly one cycle, starting at the clock edge that accepts the write.
- R5: A write with bit 2 set never changes the stored byte, whether or not it produces a pulse.
- R6: Once a pulse has fired, later writes with bit 2 set produce no pulse until `rst` has been asserted and released.
- R7: `reset_req` is high only in the cycle right after an accepted request write. Idle cycles and plain writes keep it low.
- R8: A write presented in a cycle where `rst` is high is ignored. Reset takes priority, so neither a pulse nor a store results.
- R9: While the block is disarmed, plain writes with bit 2 clear still update the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle for each byte written |
| wr_data | input | 8 | Byte being written |
| rd_data | output | 8 | Stored byte, for software to read |
| reset_req | output | 1 | One-cycle request to the reset sequencer |

## Verification
Several rules are checked on every cycle. The stored byte never holds a bit other than the type bit. The pulse never lasts longer than one cycle, and it always follows a request write. A request write leaves the read value unchanged. A disarmed block never pulses, and a reset cycle always leaves a zero byte and no pulse. Some behaviour shows only across a sequence of writes, so only the bench scenarios can confirm it. These cover the exact masked value stored for different bytes, re-arming after a reset pulse, two request writes back to back, a long quiet stretch after a pulse, and a write that lands in a reset cycle.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int RCR_DATA_W   = 8;
    localparam int RCR_REQ_BIT  = 2;
    localparam int RCR_TYPE_BIT = 1;

    typedef logic [RCR_DATA_W-1:0] rcr_byte_t;

    // Decoded form of one bus write
    typedef struct packed {
        logic      store_en;   // plain write: update stored byte
        logic      req_hit;    // request write: ask for reset
        rcr_byte_t store_val;  // masked value to keep
    } rcr_cmd_t;

    function automatic rcr_byte_t rcr_keep_mask(input int type_bit);
        rcr_byte_t m;
        m = '0;
        m[type_bit] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
    import rcr_pkg::*;
#(
    parameter int        REQ_BIT   = RCR_REQ_BIT,
    parameter rcr_byte_t KEEP_MASK = rcr_keep_mask(RCR_TYPE_BIT)
) (
    input  logic      wr_en,
    input  rcr_byte_t wr_data,
    output rcr_cmd_t  cmd
);

    always_comb begin
        cmd.req_hit   = wr_en &  wr_data[REQ_BIT];
        cmd.store_en  = wr_en & ~wr_data[REQ_BIT];
        cmd.store_val = wr_data & KEEP_MASK;
    end

endmodule

// File: rtl/rcr_store.sv
module rcr_store
    import rcr_pkg::*;
#(
    parameter rcr_byte_t KEEP_MASK = rcr_keep_mask(RCR_TYPE_BIT)
) (
    input  logic      clk,
    input  logic      rst,
    input  rcr_cmd_t  cmd,
    output rcr_byte_t value
);

    // Only bits named by KEEP_MASK get a flop; the rest read as zero
    for (genvar i = 0; i < RCR_DATA_W; i++) begin : g_bit
        if (KEEP_MASK[i]) begin : g_kept
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)               bit_q <= 1'b0;
                else if (cmd.store_en) bit_q <= cmd.store_val[i];
            end
            assign value[i] = bit_q;
        end else begin : g_zero
            assign value[i] = 1'b0;
        end
    end

    // R2: no bit outside the kept set can ever be stored
    assert_only_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (value & ~KEEP_MASK) == '0);

    // R5: a request write leaves the stored byte as it was
    assert_hold_on_req_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.req_hit |=> $stable(value));

endmodule

// File: rtl/rcr_pulse.sv
module rcr_pulse (
    input  logic clk,
    input  logic rst,
    input  logic req_hit,
    output logic req_out
);

    logic armed_q;
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            req_q   <= 1'b0;
        end else begin
            req_q <= req_hit & armed_q;
            if (req_hit) armed_q <= 1'b0;
        end
    end

    assign req_out = req_q;

    // R4: the pulse lasts exactly one cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R7: a pulse only ever follows a request write
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(req_hit));

    // R6: a disarmed block never raises a pulse
    assert_no_rearm_R6: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> !req_q);

endmodule

// File: rtl/rst_ctrl_reg.sv
module rst_ctrl_reg
    import rcr_pkg::*;
#(
    parameter int REQ_BIT  = RCR_REQ_BIT,
    parameter int TYPE_BIT = RCR_TYPE_BIT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [RCR_DATA_W-1:0] wr_data,
    output logic [RCR_DATA_W-1:0] rd_data,
    output logic                  reset_req
);

    localparam rcr_byte_t KEEP_MASK = rcr_keep_mask(TYPE_BIT);

    rcr_cmd_t  cmd;
    rcr_byte_t stored;

    rcr_decode #(.REQ_BIT(REQ_BIT), .KEEP_MASK(KEEP_MASK)) u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    rcr_store #(.KEEP_MASK(KEEP_MASK)) u_store (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .value (stored)
    );

    rcr_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .req_hit (cmd.req_hit),
        .req_out (reset_req)
    );

    assign rd_data = stored;

    // R1, R8: a reset cycle leaves a zero byte and no pulse
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !reset_req));

    // R7: idle cycles never produce a pulse
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !reset_req);

endmodule

// File: tb/rst_ctrl_reg_tb.sv
module rst_ctrl_reg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       reset_req;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rst_ctrl_reg u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .reset_req (reset_req)
    );

    typedef struct packed {
        logic       v_rst;
        logic       v_wr;
        logic [7:0] v_data;
        logic [7:0] v_rd;
        logic       v_req;
        logic [7:0] v_tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'hFB, 8'h02, 1'b0, 8'd2}, // R2 keep bit 1 only
        '{1'b0, 1'b0, 8'h00, 8'h02, 1'b0, 8'd7}, // R7 idle, R3 held
        '{1'b0, 1'b1, 8'hF9, 8'h00, 1'b0, 8'd2}, // R2 bit 1 clear
        '{1'b0, 1'b1, 8'h02, 8'h02, 1'b0, 8'd3}, // R3 read back
        '{1'b0, 1'b1, 8'h04, 8'h02, 1'b1, 8'd4}, // R4 pulse, R5 hold
        '{1'b0, 1'b0, 8'h00, 8'h02, 1'b0, 8'd4}, // R4 single cycle
        '{1'b0, 1'b1, 8'h06, 8'h02, 1'b0, 8'd6}, // R6 disarmed
        '{1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 8'd9}, // R9 plain write disarmed
        '{1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 8'd5}, // R5 hold, R6 no pulse
        '{1'b1, 1'b1, 8'h04, 8'h00, 1'b0, 8'd8}, // R8 write in reset
        '{1'b0, 1'b1, 8'hFE, 8'h00, 1'b1, 8'd6}, // R6 rearmed, R5
        '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'd7}, // R7 quiet
        '{1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'd1}, // R1 reset
        '{1'b0, 1'b1, 8'h0A, 8'h02, 1'b0, 8'd2}, // R2 mixed bits
        '{1'b0, 1'b1, 8'h0D, 8'h02, 1'b1, 8'd4}, // R4 odd request byte
        '{1'b1, 1'b1, 8'h02, 8'h00, 1'b0, 8'd8}  // R8 store blocked
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one posedge later)
    task automatic step(input logic r, input logic w, input logic [7:0] d);
        rst = r; wr_en = w; wr_data = d;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        step(1'b1, 1'b0, 8'h00);
        // R1: reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 reset_req", {7'd0, reset_req}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].v_rst, VECS[i].v_wr, VECS[i].v_data);
            check($sformatf("R%0d vec%0d rd", VECS[i].v_tag, i), rd_data, VECS[i].v_rd);
            check($sformatf("R%0d vec%0d req", VECS[i].v_tag, i), {7'd0, reset_req}, {7'd0, VECS[i].v_req});
        end

        // R6: after a pulse, many request writes and idle cycles stay quiet
        step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'h04);
        check("R4 first pulse", {7'd0, reset_req}, 8'h01);
        begin
            int pulses = 0;
            for (int k = 0; k < 50; k++) begin
                step(1'b0, (k % 3) != 0, 8'h04 | 8'(k));
                if (reset_req) pulses++;
            end
            check("R6 pulses while disarmed", 8'(pulses), 8'h00);
        end

        // R4 / R6: back-to-back request writes after a rearm give one pulse
        step(1'b1, 1'b0, 8'h00);
        rst = 1'b0; wr_en = 1'b1; wr_data = 8'h04;
        @(negedge clk);
        check("R4 b2b first", {7'd0, reset_req}, 8'h01);
        wr_data = 8'h0C;
        @(negedge clk);
        check("R6 b2b second", {7'd0, reset_req}, 8'h00);
        wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk);
        check("R7 after b2b", {7'd0, reset_req}, 8'h00);

        // R3 / R9: plain write still lands while disarmed
        step(1'b0, 1'b1, 8'hFA);
        check("R9 store while disarmed", rd_data, 8'h02);
        step(1'b0, 1'b1, 8'hFC);
        check("R5 hold after request", rd_data, 8'h02);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule